// File: doc/BRIEF.md
# Logic Self-Test Pattern and Signature Engine

This block is a complete on-chip logic self-test. It holds a small combinational circuit under test. A linear feedback shift register drives that circuit with pseudo-random vectors, and a multiple-input signature register folds the circuit's responses into a running checksum. A controller runs the whole sequence. One start pulse, with a pattern count and an expected signature, produces one pass or fail verdict.

The controller is a five-state machine. `ST_IDLE` is the state after reset, with no verdict yet. A start pulse goes to `ST_SEED`, where both registers are loaded with their fixed seeds. `ST_SEED` goes to `ST_APPLY` when the count is nonzero, or straight to `ST_JUDGE` when it is zero. `ST_APPLY` applies one pattern per cycle and moves to `ST_JUDGE` after the last pattern. `ST_JUDGE` compares the signature with the expected value and always moves to `ST_REPORT`. `ST_REPORT` holds the verdict. A new start pulse leaves `ST_REPORT` or `ST_IDLE` for `ST_SEED`. No other state looks at the start input.

Top module: `lbist_engine`

## Requirements
- R1: After reset, busy_o, done_o, pass_o and fail_o are 0, and sig_o holds the signature seed 16'hFFFF.
- R2: The pattern generator is a right-shifting Galois register, next = (s >> 1) ^ (s[0] ? 16'hB400 : 0), seeded with 16'hACE1. Its state is never zero.
- R3: The circuit under test splits its 16-bit input into hi = in[15:8] and lo = in[7:0]. Its output bits [15:8] are hi + lo, modulo 256. Its output bits [7:0] are (hi & lo) ^ {lo[6:0], lo[7]}.
- R4: The signature register starts each run at 16'hFFFF. For each pattern it updates as m = (m >> 1) ^ (m[0] ? 16'hD008 : 0) ^ response.
- R5: A run applies exactly pat_count_i patterns: the seed, then successive generator states. After that, sig_o equals the model signature. A count of 0 leaves sig_o at 16'hFFFF.
- R6: busy_o rises on the clock edge that samples start_i and stays high for exactly pat_count_i + 2 cycles. done_o rises as busy_o falls, and the two are never high together.
- R7: While done_o is high, exactly one of pass_o and fail_o is high. pass_o is high exactly when sig_o equals the expected signature captured at start. Both are low when done_o is low.
- R8: After a verdict, done_o, pass_o, fail_o and sig_o hold their values until the next start pulse. While busy_o is low, sig_o does not change.
- R9: A start pulse while busy_o is high is ignored, along with its count and expected value. The run in progress keeps its length and its signature.
- R10: A start pulse while a verdict is shown begins a fresh run from the seeds, so repeating a run gives the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse for one run |
| pat_count_i | input | 16 | Number of patterns, sampled with start_i |
| expect_sig_i | input | 16 | Expected signature, sampled with start_i |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Verdict valid |
| pass_o | output | 1 | Signature matched |
| fail_o | output | 1 | Signature mismatched |
| sig_o | output | 16 | Current signature register contents |

## Verification
A wrong generator or circuit-under-test bit corrupts the running signature on the next pattern. Because the signature register has feedback, that corruption persists and shows on sig_o and on the verdict at the end of the run. A wrong pattern count shows at once in the length of busy_o, since one cycle lost or gained changes it. It also shows in the signature, because one pattern more or less changes the compacted value. A state machine that accepts start while busy shows as a run length that matches the second count instead of the first, within that same run.

// File: rtl/lbist_pkg.sv
package lbist_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_SEED   = 3'd1,
        ST_APPLY  = 3'd2,
        ST_JUDGE  = 3'd3,
        ST_REPORT = 3'd4
    } lbist_state_e;

endpackage

// File: rtl/lbist_pattern_gen.sv
module lbist_pattern_gen #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hB400,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    output logic [W-1:0] state_o
);
    logic [W-1:0] state_q;
    logic [W-1:0] state_nx;

    // Galois step: each stage takes its upper neighbour, tapped stages also take the output bit
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_stage
            if (g == W - 1) begin : g_top
                assign state_nx[g] = TAPS[g] & state_q[0];
            end else begin : g_mid
                assign state_nx[g] = state_q[g+1] ^ (TAPS[g] & state_q[0]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEED;
        end else if (load_i) begin
            state_q <= SEED;
        end else if (adv_i) begin
            state_q <= state_nx;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/lbist_cut.sv
module lbist_cut #(
    parameter int W = 16
) (
    input  logic [W-1:0] vec_i,
    output logic [W-1:0] resp_o
);
    localparam int HALF = W / 2;

    logic [HALF-1:0] hi;
    logic [HALF-1:0] lo;
    logic [HALF-1:0] lo_rot;

    assign hi     = vec_i[W-1:HALF];
    assign lo     = vec_i[HALF-1:0];
    assign lo_rot = {lo[HALF-2:0], lo[HALF-1]};

    assign resp_o[W-1:HALF] = hi + lo;
    assign resp_o[HALF-1:0] = (hi & lo) ^ lo_rot;
endmodule

// File: rtl/lbist_sig_reg.sv
module lbist_sig_reg #(
    parameter int          W    = 16,
    parameter logic [W-1:0] TAPS = 16'hD008,
    parameter logic [W-1:0] SEED = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic         adv_i,
    input  logic [W-1:0] resp_i,
    output logic [W-1:0] sig_o
);
    logic [W-1:0] sig_q;
    logic [W-1:0] sig_nx;

    // every stage folds one response bit into its shifted-in value
    genvar g;
    generate
        for (g = 0; g < W; g++) begin : g_stage
            if (g == W - 1) begin : g_top
                assign sig_nx[g] = (TAPS[g] & sig_q[0]) ^ resp_i[g];
            end else begin : g_mid
                assign sig_nx[g] = sig_q[g+1] ^ (TAPS[g] & sig_q[0]) ^ resp_i[g];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_q <= SEED;
        end else if (load_i) begin
            sig_q <= SEED;
        end else if (adv_i) begin
            sig_q <= sig_nx;
        end
    end

    assign sig_o = sig_q;
endmodule

// File: rtl/lbist_ctrl.sv
module lbist_ctrl
    import lbist_pkg::*;
#(
    parameter int W     = 16,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] pat_count_i,
    input  logic [W-1:0]     expect_sig_i,
    input  logic [W-1:0]     sig_i,
    output logic             load_o,
    output logic             adv_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o
);
    lbist_state_e     state_q, state_d;
    logic [CNT_W-1:0] remain_q;
    logic [W-1:0]     expect_q;
    logic             verdict_q;
    logic             accept;

    assign accept = start_i && (state_q == ST_IDLE || state_q == ST_REPORT);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_SEED;
            ST_SEED:   state_d = (remain_q == '0) ? ST_JUDGE : ST_APPLY;
            ST_APPLY:  if (remain_q == CNT_W'(1)) state_d = ST_JUDGE;
            ST_JUDGE:  state_d = ST_REPORT;
            ST_REPORT: if (start_i) state_d = ST_SEED;
            default:   state_d = ST_IDLE;
        endcase
    end

    // run data: count, expected value, verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q  <= '0;
            expect_q  <= '0;
            verdict_q <= 1'b0;
        end else begin
            if (accept) begin
                remain_q <= pat_count_i;
                expect_q <= expect_sig_i;
            end else if (state_q == ST_APPLY) begin
                remain_q <= remain_q - CNT_W'(1);
            end
            if (state_q == ST_JUDGE) begin
                verdict_q <= (sig_i == expect_q);
            end
        end
    end

    // outputs
    always_comb begin
        load_o = 1'b0;
        adv_o  = 1'b0;
        busy_o = 1'b0;
        done_o = 1'b0;
        pass_o = 1'b0;
        fail_o = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_SEED: begin
                load_o = 1'b1;
                busy_o = 1'b1;
            end
            ST_APPLY: begin
                adv_o  = 1'b1;
                busy_o = 1'b1;
            end
            ST_JUDGE: busy_o = 1'b1;
            ST_REPORT: begin
                done_o = 1'b1;
                pass_o = verdict_q;
                fail_o = !verdict_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/lbist_engine.sv
module lbist_engine #(
    parameter int          W          = 16,
    parameter int          CNT_W      = 16,
    parameter logic [W-1:0] GEN_TAPS   = 16'hB400,
    parameter logic [W-1:0] GEN_SEED   = 16'hACE1,
    parameter logic [W-1:0] SIG_TAPS   = 16'hD008,
    parameter logic [W-1:0] SIG_SEED   = 16'hFFFF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] pat_count_i,
    input  logic [W-1:0]     expect_sig_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             pass_o,
    output logic             fail_o,
    output logic [W-1:0]     sig_o
);
    logic         load;
    logic         adv;
    logic [W-1:0] lfsr_q;
    logic [W-1:0] resp;
    logic [W-1:0] sig_q;

    lbist_pattern_gen #(.W(W), .TAPS(GEN_TAPS), .SEED(GEN_SEED)) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .adv_i   (adv),
        .state_o (lfsr_q)
    );

    lbist_cut #(.W(W)) u_cut (
        .vec_i  (lfsr_q),
        .resp_o (resp)
    );

    lbist_sig_reg #(.W(W), .TAPS(SIG_TAPS), .SEED(SIG_SEED)) u_sig (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .adv_i  (adv),
        .resp_i (resp),
        .sig_o  (sig_q)
    );

    lbist_ctrl #(.W(W), .CNT_W(CNT_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pat_count_i  (pat_count_i),
        .expect_sig_i (expect_sig_i),
        .sig_i        (sig_q),
        .load_o       (load),
        .adv_o        (adv),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .pass_o       (pass_o),
        .fail_o       (fail_o)
    );

    assign sig_o = sig_q;
endmodule

// File: rtl/lbist_engine_checker.sv
module lbist_engine_checker #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         busy_o,
    input logic         done_o,
    input logic         pass_o,
    input logic         fail_o,
    input logic [W-1:0] sig_o,
    input logic [W-1:0] lfsr_state
);
    assert_lfsr_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0);

    assert_busy_needs_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_busy_done_mutex_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_one_verdict_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (pass_o ^ fail_o));

    assert_no_verdict_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> (!pass_o && !fail_o));

    assert_verdict_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(pass_o) && $stable(sig_o)));

    assert_sig_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> $stable(sig_o));
endmodule

bind lbist_engine lbist_engine_checker #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .pass_o     (pass_o),
    .fail_o     (fail_o),
    .sig_o      (sig_o),
    .lfsr_state (lfsr_q)
);

// File: tb/lbist_engine_test.sv
module lbist_engine_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] pat_count_i = '0;
    logic [15:0] expect_sig_i = '0;
    logic        busy_o, done_o, pass_o, fail_o;
    logic [15:0] sig_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit finished = 0;

    lbist_engine uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .pat_count_i  (pat_count_i),
        .expect_sig_i (expect_sig_i),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .pass_o       (pass_o),
        .fail_o       (fail_o),
        .sig_o        (sig_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !finished) begin
            failures = failures + 1;
            $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<%0d", cycles, WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
            $finish;
        end
    end

    // reference model from the requirements
    function automatic logic [15:0] gen_step(input logic [15:0] s);
        return (s >> 1) ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [15:0] cut_resp(input logic [15:0] v);
        logic [7:0] h, l;
        h = v[15:8];
        l = v[7:0];
        return {h + l, (h & l) ^ {l[6:0], l[7]}};
    endfunction

    function automatic logic [15:0] model_sig(input int n);
        logic [15:0] g, m;
        g = 16'hACE1;
        m = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            m = (m >> 1) ^ (m[0] ? 16'hD008 : 16'h0000) ^ cut_resp(g);
            g = gen_step(g);
        end
        return m;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // launch one run, optionally fire a stray start while busy
    task automatic do_run(input int n, input logic [15:0] exp_sig, input int stray_at,
                          output int busy_len);
        int guard;
        @(negedge clk);
        start_i      = 1'b1;
        pat_count_i  = 16'(n);
        expect_sig_i = exp_sig;
        @(negedge clk);
        start_i  = 1'b0;
        busy_len = 0;
        guard    = 0;
        while (!done_o && guard < 5000) begin
            if (busy_o) busy_len++;
            if (stray_at > 0 && busy_len == stray_at) begin
                start_i      = 1'b1;
                pat_count_i  = 16'd3;
                expect_sig_i = ~exp_sig;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        start_i = 1'b0;
    endtask

    task automatic run_and_check(input int n, input bit want_pass, input int stray_at, input string tag);
        logic [15:0] golden, exp_sig;
        int blen;
        golden  = model_sig(n);
        exp_sig = want_pass ? golden : golden ^ (16'h1 << ($urandom % 16));
        do_run(n, exp_sig, stray_at, blen);
        check(blen == n + 2, {tag, " R6 busy length"}, blen, n + 2);
        check(sig_o == golden, {tag, " R5 signature"}, sig_o, golden);
        check(done_o && pass_o == want_pass && fail_o == !want_pass,
              {tag, " R7 verdict"}, {done_o, pass_o, fail_o}, {1'b1, want_pass, !want_pass});
        repeat (3) @(negedge clk);
        check(done_o && pass_o == want_pass && sig_o == golden && !busy_o,
              {tag, " R8 hold"}, sig_o, golden);
    endtask

    initial begin
        void'($urandom(32'h1b157));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy_o && !done_o && !pass_o && !fail_o, "R1 reset flags",
              {busy_o, done_o, pass_o, fail_o}, 0);
        check(sig_o == 16'hFFFF, "R1 reset signature", sig_o, 16'hFFFF);

        // R5 zero patterns: signature stays at seed
        run_and_check(0, 1'b1, 0, "count0");
        check(sig_o == 16'hFFFF, "R5 zero count seed", sig_o, 16'hFFFF);
        // R2 R3 R4 single pattern, hand-derivable
        run_and_check(1, 1'b1, 0, "count1");
        run_and_check(2, 1'b0, 0, "count2_fail");
        // R9 stray start while busy
        run_and_check(50, 1'b1, 10, "stray_R9");
        run_and_check(40, 1'b0, 1, "stray_first_R9");
        // R10 repeat same run gives same signature
        run_and_check(77, 1'b1, 0, "repeat_a_R10");
        run_and_check(77, 1'b1, 0, "repeat_b_R10");
        // R2 long run covers many generator states
        run_and_check(1000, 1'b1, 0, "long_R2");

        // random runs
        for (int k = 0; k < 30; k++) begin
            run_and_check(int'($urandom % 300), ($urandom % 2) == 1, 0, "rand_R4");
        end

        // R1 reset after activity
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && sig_o == 16'hFFFF, "R1 reset again", sig_o, 16'hFFFF);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule